// File: doc/BRIEF.md
# Pipelined Converter Bit-Weight Corrector

This block turns the one-bit decisions of a fifteen-stage pipelined converter core into a corrected twelve-bit sample code. The core resolves a sample one stage per clock. Stage k gives its decision k cycles after stage 0 gives its decision. The corrector delays every stage lane so that all fifteen decisions of one sample line up. It then adds a calibrated weight for each decision that is 1, rounds the total to a whole code and limits it to twelve bits. A new sample may enter on every clock.

The weights sit in a fifteen-entry coefficient store inside the block. A write port lets a calibration engine replace them one entry at a time. After reset the store holds plain binary weights, so the block gives a usable code before any calibration has run.

Top module: `adc_corr`

## Requirements
- R1: Bit k of `raw_bits` that is presented k cycles after the cycle in which `sample_valid` was high belongs to that sample. All fifteen lanes are combined for the same sample, even when samples follow each other on every clock.
- R2: `out_valid` is high in exactly the 16th cycle after each cycle in which `sample_valid` was high, and is low in all other cycles. One sample per clock is sustained.
- R3: A coefficient is an unsigned 16-bit number with 4 fraction bits. `out_code` equals the sum of the coefficients of the stages whose bit is 1, rounded to an integer.
- R4: A sample whose fifteen bits are all 0 gives `out_code` = 0.
- R5: A rounded sum above 4095 gives `out_code` = 4095.
- R6: The sum rounds to nearest, with an exact half rounding up. A fraction of 8/16 or more adds one code and a fraction of 7/16 or less is dropped.
- R7: After reset, coefficient k holds 2^(11-k) (the raw value 2^(15-k)) for stages 0 to 11, and 0 for stages 12 to 14.
- R8: A clock edge with `coef_wr_en` high and `coef_wr_idx` in 0..14 replaces that coefficient with `coef_wr_val`. Index 15 changes no coefficient.
- R9: `out_code` is 0 whenever `out_valid` is low. During and right after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_bits | input | 15 | Stage decisions; bit k comes from stage k |
| sample_valid | input | 1 | High in the cycle that stage 0 gives a sample's first decision |
| coef_wr_en | input | 1 | Coefficient write strobe |
| coef_wr_idx | input | 4 | Stage whose coefficient is written |
| coef_wr_val | input | 16 | New coefficient, 4 fraction bits |
| out_code | output | 12 | Corrected sample code |
| out_valid | output | 1 | High when `out_code` holds a sample |

## Verification
The assertions assume that the stage decisions of a sample follow the fixed one-cycle skew, and that `raw_bits` lanes outside a valid sample do not matter. They also assume that coefficient writes are not made while samples are being summed. The stimulus builds every sample's lane bits from that skew, driving lane k in the cycle k after the sample's first cycle. All coefficient writes happen while the pipeline is empty. Idle lanes are driven with the skewed bits of the neighbouring samples, or with zero.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int DFLT_STAGES = 15;
    localparam int DFLT_COEF_W = 16;
    localparam int DFLT_FRAC_W = 4;
    localparam int DFLT_OUT_W  = 12;

    // Binary weight used for stage k until calibration rewrites it.
    function automatic int weight_of(input int k, input int out_w, input int frac_w);
        if (k < out_w)
            return 1 << (frac_w + out_w - 1 - k);
        return 0;
    endfunction

endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_shift
            logic [WIDTH-1:0] sr_q [DEPTH];
            logic [WIDTH-1:0] sr_d [DEPTH];

            always_comb begin
                sr_d[0] = din;
                for (int i = 1; i < DEPTH; i++)
                    sr_d[i] = sr_q[i-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++)
                        sr_q[i] <= '0;
                end else begin
                    for (int i = 0; i < DEPTH; i++)
                        sr_q[i] <= sr_d[i];
                end
            end

            assign dout = sr_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/adc_corr_adder.sv
module adc_corr_adder #(
    parameter int N      = 8,
    parameter int COEF_W = 16,
    parameter int SUM_W  = 20
) (
    input  logic [N-1:0]        bits,
    input  logic [N*COEF_W-1:0] coefs,
    output logic [SUM_W-1:0]    sum
);

    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i])
                sum = sum + SUM_W'(coefs[i*COEF_W +: COEF_W]);
        end
    end

endmodule

// File: rtl/adc_corr.sv
module adc_corr #(
    parameter int N_STAGES = adc_corr_pkg::DFLT_STAGES,
    parameter int COEF_W   = adc_corr_pkg::DFLT_COEF_W,
    parameter int FRAC_W   = adc_corr_pkg::DFLT_FRAC_W,
    parameter int OUT_W    = adc_corr_pkg::DFLT_OUT_W,
    parameter int IDX_W    = $clog2(N_STAGES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] raw_bits,
    input  logic                sample_valid,
    input  logic                coef_wr_en,
    input  logic [IDX_W-1:0]    coef_wr_idx,
    input  logic [COEF_W-1:0]   coef_wr_val,
    output logic [OUT_W-1:0]    out_code,
    output logic                out_valid
);

    localparam int ALIGN = N_STAGES - 1;
    localparam int LO_N  = (N_STAGES + 1) / 2;
    localparam int HI_N  = N_STAGES - LO_N;
    localparam int SUM_W = COEF_W + $clog2(N_STAGES + 1);
    localparam logic [SUM_W:0] HALF     = (SUM_W+1)'(1) << (FRAC_W - 1);
    localparam logic [SUM_W:0] CODE_MAX = (SUM_W+1)'((1 << OUT_W) - 1);

    typedef logic [N_STAGES-1:0][COEF_W-1:0] coef_arr_t;

    typedef struct packed {
        coef_arr_t        coef;
        logic [SUM_W-1:0] sum_lo;
        logic [SUM_W-1:0] sum_hi;
        logic             s1_valid;
        logic [OUT_W-1:0] code;
        logic             valid;
    } state_t;

    function automatic coef_arr_t dflt_table();
        coef_arr_t t;
        for (int k = 0; k < N_STAGES; k++)
            t[k] = COEF_W'(adc_corr_pkg::weight_of(k, OUT_W, FRAC_W));
        return t;
    endfunction

    state_t st_q, st_d;

    // Lane alignment: stage k waits ALIGN-k cycles for the last stage.
    logic [N_STAGES-1:0] aligned;
    logic                valid_al;

    generate
        for (genvar k = 0; k < N_STAGES; k++) begin : g_lane
            adc_corr_delay #(.DEPTH(ALIGN - k), .WIDTH(1)) u_dly (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_bits[k]),
                .dout (aligned[k])
            );
        end
    endgenerate

    adc_corr_delay #(.DEPTH(ALIGN), .WIDTH(1)) u_vdly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sample_valid),
        .dout (valid_al)
    );

    // Two half-width adder trees feed the first summation register.
    logic [SUM_W-1:0]        lo_sum, hi_sum;
    logic [LO_N*COEF_W-1:0]  lo_coefs;
    logic [HI_N*COEF_W-1:0]  hi_coefs;

    assign lo_coefs = st_q.coef[LO_N-1:0];
    assign hi_coefs = st_q.coef[N_STAGES-1:LO_N];

    adc_corr_adder #(.N(LO_N), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_add_lo (
        .bits (aligned[LO_N-1:0]),
        .coefs(lo_coefs),
        .sum  (lo_sum)
    );

    adc_corr_adder #(.N(HI_N), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_add_hi (
        .bits (aligned[N_STAGES-1:LO_N]),
        .coefs(hi_coefs),
        .sum  (hi_sum)
    );

    logic [SUM_W:0] total, scaled;

    always_comb begin
        st_d = st_q;

        if (coef_wr_en && (int'(coef_wr_idx) < N_STAGES))
            st_d.coef[coef_wr_idx] = coef_wr_val;

        st_d.s1_valid = valid_al;
        st_d.sum_lo   = valid_al ? lo_sum : '0;
        st_d.sum_hi   = valid_al ? hi_sum : '0;

        total  = {1'b0, st_q.sum_lo} + {1'b0, st_q.sum_hi} + HALF;
        scaled = total >> FRAC_W;

        st_d.valid = st_q.s1_valid;
        if (!st_q.s1_valid)
            st_d.code = '0;
        else if (scaled > CODE_MAX)
            st_d.code = CODE_MAX[OUT_W-1:0];
        else
            st_d.code = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.coef <= dflt_table();
        end else begin
            st_q <= st_d;
        end
    end

    assign out_code  = st_q.code;
    assign out_valid = st_q.valid;

    // Taps for the bound checker.
    logic             s1_valid_q;
    logic [SUM_W-1:0] sum_lo_q, sum_hi_q;
    assign s1_valid_q = st_q.s1_valid;
    assign sum_lo_q   = st_q.sum_lo;
    assign sum_hi_q   = st_q.sum_hi;

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
    parameter int N_STAGES = 15,
    parameter int FRAC_W   = 4,
    parameter int OUT_W    = 12,
    parameter int SUM_W    = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_code,
    input logic             s1_valid,
    input logic [SUM_W-1:0] sum_lo,
    input logic [SUM_W-1:0] sum_hi
);

    localparam int LAT = N_STAGES + 1;
    localparam logic [SUM_W:0] SAT_AT =
        (SUM_W+1)'(((1 << OUT_W) - 1)) << FRAC_W;
    localparam logic [OUT_W-1:0] TOP = '1;

    logic [LAT-1:0] vtrack_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            vtrack_q <= '0;
        else
            vtrack_q <= {vtrack_q[LAT-2:0], sample_valid};
    end

    logic [SUM_W:0] both;
    assign both = {1'b0, sum_lo} + {1'b0, sum_hi};

    // R2: output valid trails the input strobe by the fixed latency
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vtrack_q[LAT-1]);

    // R9: no code while no sample is presented
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_code == '0);

    // R5: a large staged sum ends as the top code
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && both >= SAT_AT) |=> (out_valid && out_code == TOP));

    // R4: an empty sum ends as code zero
    a_r4_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && both == '0) |=> (out_valid && out_code == '0));

endmodule

bind adc_corr adc_corr_chk #(
    .N_STAGES(N_STAGES),
    .FRAC_W  (FRAC_W),
    .OUT_W   (OUT_W),
    .SUM_W   (SUM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .out_valid   (out_valid),
    .out_code    (out_code),
    .s1_valid    (s1_valid_q),
    .sum_lo      (sum_lo_q),
    .sum_hi      (sum_hi_q)
);

// File: tb/adc_corr_bench.sv
module adc_corr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] raw_bits = '0;
    logic        sample_valid = 1'b0;
    logic        coef_wr_en = 1'b0;
    logic [3:0]  coef_wr_idx = '0;
    logic [15:0] coef_wr_val = '0;
    logic [11:0] out_code;
    logic        out_valid;

    always #5 clk = ~clk;

    adc_corr u_adc_corr (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_bits    (raw_bits),
        .sample_valid(sample_valid),
        .coef_wr_en  (coef_wr_en),
        .coef_wr_idx (coef_wr_idx),
        .coef_wr_val (coef_wr_val),
        .out_code    (out_code),
        .out_valid   (out_valid)
    );

    // Table run with reset weights: pattern (bit k = stage k) and code.
    localparam int NV = 9;
    localparam logic [14:0] VPAT [NV] = '{
        15'h0000, 15'h0FFF, 15'h7FFF, 15'h0001, 15'h0800,
        15'h0555, 15'h0AAA, 15'h0003, 15'h7000 };
    localparam int VEXP [NV] = '{
        0, 4095, 4095, 2048, 1, 2730, 1365, 3072, 0 };

    int n_chk = 0;
    int n_bad = 0;
    int mc [15];

    logic [14:0] sb [128];
    logic        sv [128];
    int          se [128];
    int          ns;

    task automatic model_reset();
        for (int k = 0; k < 15; k++)
            mc[k] = (k < 12) ? (1 << (15 - k)) : 0;
    endtask

    function automatic int model(input logic [14:0] b);
        int s = 0;
        int r;
        for (int k = 0; k < 15; k++)
            if (b[k]) s += mc[k];
        r = (s + 8) >> 4;
        if (r > 4095) r = 4095;
        return r;
    endfunction

    task automatic add(input logic [14:0] b, input logic v);
        sb[ns] = b;
        sv[ns] = v;
        se[ns] = model(b);
        ns++;
    endtask

    task automatic play(input string tag);
        for (int t = 0; t < ns + 17; t++) begin
            @(negedge clk);
            for (int k = 0; k < 15; k++)
                raw_bits[k] = (t - k >= 0 && t - k < ns) ? sb[t-k][k] : 1'b0;
            sample_valid = (t < ns) ? sv[t] : 1'b0;
            if (t >= 16) begin
                int s = t - 16;
                logic ev = (s < ns) ? sv[s] : 1'b0;
                int ec = ev ? se[s] : 0;
                n_chk++;
                if (out_valid !== ev || int'(out_code) != ec) begin
                    n_bad++;
                    $display("FAIL %s slot %0d: valid=%0b code=%0d, expected valid=%0b code=%0d",
                             tag, s, out_valid, out_code, ev, ec);
                end
            end
        end
        ns = 0;
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        coef_wr_en  = 1'b1;
        coef_wr_idx = 4'(idx);
        coef_wr_val = 16'(val);
        if (idx < 15) mc[idx] = val;
        @(negedge clk);
        coef_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        raw_bits = '0;
        sample_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0 || out_code !== 12'd0) begin
                n_bad++;
                $display("FAIL R9 reset: valid=%0b code=%0d, expected valid=0 code=0",
                         out_valid, out_code);
            end
        end
        rst_n = 1'b1;
        model_reset();
    endtask

    bit done = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (!done && cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        ns = 0;
        do_reset();

        // R1 R3 R7: back-to-back table samples with the reset weights
        for (int i = 0; i < NV; i++) begin
            sb[i] = VPAT[i];
            sv[i] = 1'b1;
            se[i] = VEXP[i];
        end
        ns = NV;
        play("R1/R7");

        // R2 R9: gaps in the strobe; lanes still carry data
        add(15'h0123, 1'b1); add(15'h7FFF, 1'b0); add(15'h0F0F, 1'b1);
        add(15'h0555, 1'b0); add(15'h0555, 1'b0); add(15'h0400, 1'b1);
        add(15'h0AAA, 1'b1); add(15'h3333, 1'b0);
        play("R2");

        // R4: all-zero samples among others
        add(15'h0000, 1'b1); add(15'h0FFF, 1'b1); add(15'h0000, 1'b1);
        play("R4");

        // R8: calibrated weights, plus a write to index 15 that must change nothing
        wr(0, 16'hFFF0);
        wr(1, 16'h0100);
        wr(12, 16'h0008);
        wr(13, 16'h0007);
        wr(15, 16'hFFFF);
        for (int k = 0; k < 15; k++) add(15'(1 << k), 1'b1);
        play("R8");

        // R5: saturation
        add(15'h0003, 1'b1); add(15'h7FFF, 1'b1); add(15'h0001, 1'b1);
        play("R5");

        // R6: half rounds up, 7/16 drops, 15/16 rounds up
        add(15'h1000, 1'b1); add(15'h2000, 1'b1); add(15'h3000, 1'b1);
        play("R6");

        // R3: mixed sums under calibrated weights
        add(15'h0006, 1'b1); add(15'h1FFE, 1'b1); add(15'h0A0A, 1'b1);
        play("R3");

        // R7: reset restores binary weights
        do_reset();
        add(15'h0001, 1'b1); add(15'h1000, 1'b1); add(15'h0002, 1'b1);
        play("R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule